// File: doc/BRIEF.md
# Converter Start/Ready Sequencer

This block sits between a host and a successive-approximation converter that reports its state on an end-of-conversion line (EOC: low while busy, high when done). The host raises a start request of any length, possibly unrelated to the block's clock. The block brings the request into the clock domain and holds it in a request latch. When the converter is free, it sends a single-clock start pulse to the converter.

A small loadable counter times the settling gap after a conversion. It is preset to 11 when the start pulse is issued. It stays frozen until the converter has dropped EOC and then raised it again, and it then counts once per clock. When it wraps from 15 to 0, the carry does two things: it clears the request latch, and it appears on the `ready` output as a one-clock pulse. That pulse tells the host that the result has moved to the converter's output and that a new cycle may begin.

A request held high is therefore latched again right after each carry, which gives back-to-back conversions. A request that arrives while a conversion is running is absorbed by the latch that is already set, so it does not start a second conversion.

Top module: `conv_sequencer`

## Requirements
- R1: During and after reset, `convStart` and `ready` are low, and no start pulse is issued until a start request has been seen.
- R2: Every start pulse on `convStart` is exactly one clock cycle wide.
- R3: A start request held high for any length shorter than one conversion, with edges at arbitrary times relative to the clock, yields exactly one start pulse and one `ready` pulse.
- R4: The gap counter is preset to 11 when the start pulse is issued. It does not advance until EOC has been sampled low and then high after that start.
- R5: `ready` is a one-cycle pulse that marks the counter wrapping from 15 to 0. Let edge k be the first clock edge at which EOC is sampled high after it was low. Then `ready` is high in the cycle that follows edge k+4.
- R6: The carry clears the request latch. A second request that begins and ends while a conversion is in progress causes no additional conversion.
- R7: A start request held high produces continuous conversions. With a 40-clock conversion, consecutive start pulses are at least 44 clocks apart.
- R8: No start pulse is issued between a start pulse and the `ready` pulse that ends its cycle.
- R9: When the converter holds EOC high for several clocks after the start pulse before dropping it, the `ready` timing of R5 still holds, measured from the later EOC rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Host start request, asynchronous, level sensitive |
| convEoc | input | 1 | Converter end-of-conversion: low while busy, high when done |
| convStart | output | 1 | One-clock start pulse to the converter |
| ready | output | 1 | One-clock pulse: data transferred, new cycle allowed |

## Verification
The hardest case to reach is a converter that leaves EOC high for some clocks after accepting a start. In that window the counter must not treat the stale high level from the previous conversion as completion. If it did, `ready` would come early and the next start could cut into a running conversion. The bench's converter model has an adjustable delay before it drops EOC, and the bench measures the distance from the real EOC rise to `ready`. A second hard case is a request that arrives mid-conversion. The bench reaches it with a second short asynchronous pulse placed well inside the 40-clock busy window, then confirms that only one conversion occurs.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // Strobes from the control FSM to the gap counter
  typedef struct packed {
    logic load;   // preset the counter (issued with the start pulse)
    logic cntEn;  // advance the counter
  } seqStrobeT;
endpackage

// File: rtl/seq_counter.sv
module seq_counter
  import seq_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int LOAD_VAL = 11
) (
  input  logic      clk,
  input  logic      rstN,
  input  seqStrobeT strobe,
  output logic      wrap
);
  localparam logic [CNT_W-1:0] LOAD_C = CNT_W'(LOAD_VAL);
  localparam logic [CNT_W-1:0] MAX_C  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strobe.load)  cnt <= LOAD_C;
    else if (strobe.cntEn) cnt <= cnt + 1'b1;
  end

  // Carry: counter enabled at its top value, wraps on this edge
  assign wrap = strobe.cntEn && (cnt == MAX_C);

  // R4
  cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.cntEn) |=> $stable(cnt));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      convEoc,
  input  logic      wrap,
  output seqStrobeT strobe,
  output logic      convStart,
  output logic      ready
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic startSync;
  logic reqLatch;
  logic busy;
  logic eocDropped;
  logic issue;

  // Bring the asynchronous request into the clock domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], startReq};
  end
  assign startSync = syncQ[SYNC_STAGES-1];

  // Request latch: set by the request, cleared by the carry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          reqLatch <= 1'b0;
    else if (wrap)      reqLatch <= 1'b0;
    else if (startSync) reqLatch <= 1'b1;
  end

  assign issue = reqLatch && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      eocDropped <= 1'b0;
      convStart  <= 1'b0;
      ready      <= 1'b0;
    end else begin
      convStart <= issue;
      ready     <= wrap;
      if (issue)     busy <= 1'b1;
      else if (wrap) busy <= 1'b0;
      if (issue)                eocDropped <= 1'b0;
      else if (busy && !convEoc) eocDropped <= 1'b1;
    end
  end

  always_comb begin
    strobe.load  = issue;
    strobe.cntEn = busy && eocDropped && convEoc;
  end

  // R2
  start_one_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);
  // R5
  ready_one_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ready);
  // R8
  wrap_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrap |-> busy);
  // R8
  no_start_at_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !convStart);
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import seq_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int LOAD_VAL    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic convEoc,
  output logic convStart,
  output logic ready
);
  seqStrobeT strobe;
  logic wrap;

  seq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .convEoc(convEoc),
    .wrap(wrap), .strobe(strobe), .convStart(convStart), .ready(ready)
  );

  seq_counter #(.CNT_W(CNT_W), .LOAD_VAL(LOAD_VAL)) uCnt (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrap(wrap)
  );
endmodule

// File: tb/tb_conv_sequencer.sv
module tb_conv_sequencer;
  localparam int CONV_CLKS = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic convEoc;
  logic convStart, ready;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int dropDelay = 0;
  int mCnt;

  always #10 clk = ~clk;

  conv_sequencer dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .convEoc(convEoc),
    .convStart(convStart), .ready(ready)
  );

  // Converter model: EOC falls dropDelay clocks after start, rises after CONV_CLKS
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt <= 0; convEoc <= 1'b1;
    end else if (convStart) begin
      mCnt <= 1;
      if (dropDelay == 0) convEoc <= 1'b0;
    end else if (mCnt != 0) begin
      if (mCnt == dropDelay) convEoc <= 1'b0;
      if (mCnt == CONV_CLKS) begin convEoc <= 1'b1; mCnt <= 0; end
      else mCnt <= mCnt + 1;
    end
  end

  // Monitor sampled on the falling edge
  logic prevEoc = 1'b1, prevStart = 1'b0, prevReady = 1'b0;
  int eocRiseCyc = 0, lastStartCyc = -1;
  int startCount, readyCount, lastReadyDelay, minPeriod;
  int startRun, readyRun, maxStartRun, maxReadyRun;
  bit busyMon, startWhileBusy;

  task automatic clearMon();
    startCount = 0; readyCount = 0; lastReadyDelay = -1; minPeriod = 1000000;
    startRun = 0; readyRun = 0; maxStartRun = 0; maxReadyRun = 0;
    busyMon = 0; startWhileBusy = 0; lastStartCyc = -1;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (convEoc && !prevEoc) eocRiseCyc = cyc;
    if (ready && !prevReady) begin
      readyCount++; lastReadyDelay = cyc - eocRiseCyc; busyMon = 0;
    end
    if (convStart && !prevStart) begin
      startCount++;
      if (busyMon) startWhileBusy = 1;
      busyMon = 1;
      if (lastStartCyc >= 0 && cyc - lastStartCyc < minPeriod) minPeriod = cyc - lastStartCyc;
      lastStartCyc = cyc;
    end
    startRun = convStart ? startRun + 1 : 0;
    readyRun = ready ? readyRun + 1 : 0;
    if (startRun > maxStartRun) maxStartRun = startRun;
    if (readyRun > maxReadyRun) maxReadyRun = readyRun;
    prevEoc = convEoc; prevStart = convStart; prevReady = ready;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  // Async pulse: start offset ns after an edge, lasting len clocks
  task automatic pulse(input int offset, input int len);
    @(posedge clk); #(offset);
    startReq = 1'b1;
    waitClks(len); #(offset);
    startReq = 1'b0;
  endtask

  task automatic runReset();
    rstN = 1'b0;
    waitClks(3);
    @(negedge clk);
    check(convStart == 1'b0, "R1 start in reset", convStart, 0);
    check(ready == 1'b0, "R1 ready in reset", ready, 0);
    rstN = 1'b1;
    clearMon();
    waitClks(30);
    check(startCount == 0, "R1 no start without request", startCount, 0);
  endtask

  task automatic runShortPulse();
    clearMon(); dropDelay = 0;
    pulse(7, 3);
    waitClks(120);
    check(startCount == 1, "R3 one start", startCount, 1);
    check(readyCount == 1, "R3 one ready", readyCount, 1);
    check(maxStartRun == 1, "R2 start width", maxStartRun, 1);
    check(maxReadyRun == 1, "R5 ready width", maxReadyRun, 1);
    check(lastReadyDelay == 5, "R5 eoc to ready", lastReadyDelay, 5);
    check(lastReadyDelay == 5, "R4 counter held until eoc", lastReadyDelay, 5);
  endtask

  task automatic runLongAsyncPulse();
    clearMon(); dropDelay = 0;
    pulse(13, 30);
    waitClks(120);
    check(startCount == 1, "R3 long pulse one start", startCount, 1);
    check(readyCount == 1, "R3 long pulse one ready", readyCount, 1);
  endtask

  task automatic runRetrigger();
    clearMon(); dropDelay = 0;
    pulse(3, 2);
    waitClks(12);
    pulse(11, 5);
    waitClks(120);
    check(startCount == 1, "R6 mid-conversion request absorbed", startCount, 1);
    check(readyCount == 1, "R6 single ready", readyCount, 1);
  endtask

  task automatic runHeld();
    clearMon(); dropDelay = 0;
    @(posedge clk); #5 startReq = 1'b1;
    waitClks(200);
    #5 startReq = 1'b0;
    waitClks(120);
    check(startCount >= 4, "R7 continuous conversions", startCount, 4);
    check(minPeriod >= 44, "R7 min period", minPeriod, 44);
    check(startWhileBusy == 0, "R8 no start while busy", startWhileBusy, 0);
    check(maxStartRun == 1, "R2 start width held", maxStartRun, 1);
    check(readyCount == startCount, "R7 ready per start", readyCount, startCount);
  endtask

  task automatic runSlowEoc();
    clearMon(); dropDelay = 3;
    pulse(9, 2);
    waitClks(120);
    check(startCount == 1, "R9 one start", startCount, 1);
    check(lastReadyDelay == 5, "R9 eoc to ready with late drop", lastReadyDelay, 5);
    // back-to-back with late drop
    clearMon();
    @(posedge clk); #5 startReq = 1'b1;
    waitClks(110);
    #5 startReq = 1'b0;
    waitClks(120);
    check(startWhileBusy == 0, "R9 no overlap with late drop", startWhileBusy, 0);
    check(lastReadyDelay == 5, "R9 last ready delay", lastReadyDelay, 5);
    dropDelay = 0;
  endtask

  initial begin
    clearMon();
    runReset();
    runShortPulse();
    runLongAsyncPulse();
    runRetrigger();
    runHeld();
    runSlowEoc();
    clearMon();
    waitClks(60);
    check(startCount == 0, "R1 idle stays idle", startCount, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitClks(150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule